// File: doc/BRIEF.md
# Configurable Registered Fan-Out Buffer

This block is a clocked register stage on a memory module's command and address path. Each rising clock edge captures a set of general data lines and three control lines (clock enable, termination enable and an active-low chip select). The captured values drive one or two copies of each output. Two static configuration inputs pick one of three layouts.

- Wide layout: 22 data lines and 3 control lines pass straight through, 25 bits in and 25 bits out.
- Duplicated layouts: 11 data lines and the 3 control lines are registered and each one drives an A copy and a B copy. Two fixed lane patterns decide which data lines take part.

An asynchronous active-low reset clears every register and pulls all outputs low immediately. The release of that reset is synchronised to the clock. The data outputs are held whenever both the chip-select input and a second, independent select input are inactive (high). The control outputs keep following their inputs on every edge. Reset overrides the select gating.

Top module: `fanout_reg_buf`

## Requirements
- R1: Inputs are sampled on the rising clock edge, and outputs change only after that edge, one cycle of latency. A change on the inputs between edges does not reach the outputs.
- R2: With `cfg_dup` = 0 (wide layout), `datq_a_o[i]` takes `dat_i[i]` for all 22 bits, and `cke_a_o`, `odt_a_o`, `cs_n_a_o` take `cke_i`, `odt_i`, `cs_n_i`. Every B output is 0. `cfg_alt` has no effect in this layout.
- R3: With `cfg_dup` = 1 and `cfg_alt` = 0 (lane pattern A), data indices 1, 2, 4, 5 and 7 to 13 (mask 22'h03FB6) drive both `datq_a_o[i]` and `datq_b_o[i]`. All other data output bits are 0.
- R4: With `cfg_dup` = 1 and `cfg_alt` = 1 (lane pattern B), data indices 0 to 5, 7, 8, 9, 11 and 12 (mask 22'h01BBF) drive both A and B data copies. All other data output bits are 0.
- R5: With `cfg_dup` = 1, each registered control line drives both its A copy and its B copy.
- R6: While `rst_n` is 0, every output is 0. Asserting `rst_n` clears the outputs at once, with no clock edge needed.
- R7: After `rst_n` rises, outputs stay 0 through the next two rising edges. The third rising edge is the first one that captures inputs.
- R8: When `cs_n_i` and `csr_n_i` are both 1 at a rising edge, `datq_a_o` and `datq_b_o` keep their values across that edge.
- R9: When either `cs_n_i` or `csr_n_i` is 0 at a rising edge, the data outputs update at that edge.
- R10: The control outputs (`cke_*`, `odt_*`, `cs_n_*`) update on every edge, whatever the select inputs are.
- R11: Reset clears the data outputs even while the select gating is holding them.
- R12: A change of `cfg_dup` or `cfg_alt` between edges takes effect on the data and control outputs at the next ungated rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dup | input | 1 | 0: wide layout, 1: duplicated layout |
| cfg_alt | input | 1 | Lane pattern in duplicated layout: 0 = A, 1 = B |
| csr_n_i | input | 1 | Secondary active-low select for data gating |
| dat_i | input | 22 | General data inputs |
| cke_i | input | 1 | Clock-enable input |
| odt_i | input | 1 | Termination-enable input |
| cs_n_i | input | 1 | Active-low chip select, registered and used for gating |
| datq_a_o | output | 22 | Registered data, A copy |
| datq_b_o | output | 22 | Registered data, B copy |
| cke_a_o | output | 1 | Registered clock enable, A copy |
| cke_b_o | output | 1 | Registered clock enable, B copy |
| odt_a_o | output | 1 | Registered termination enable, A copy |
| odt_b_o | output | 1 | Registered termination enable, B copy |
| cs_n_a_o | output | 1 | Registered chip select, A copy |
| cs_n_b_o | output | 1 | Registered chip select, B copy |

## Verification
The assertions check several properties on every clock cycle:
- outputs are low while reset is held;
- data outputs are stable after an edge where both selects were high;
- each control output equals the previous cycle's input;
- A and B copies agree in the duplicated layouts;
- all B outputs are zero in the wide layout.

Some behaviour can only be shown by the bench's scenarios:
- the exact lane masks of patterns A and B;
- the immediate clear between clock edges and its priority over held data;
- the three-edge release sequence;
- a layout change taking hold at the following edge.

// File: rtl/fob_pkg.sv
`timescale 1ns/1ps
package fob_pkg;
  localparam int FOB_DAT_W = 22;
  localparam int FOB_CTL_W = 3;

  typedef enum logic [1:0] {
    FOB_WIDE  = 2'd0,
    FOB_DUP_A = 2'd1,
    FOB_DUP_B = 2'd2
  } fob_mode_e;

  typedef struct packed {
    logic cke;
    logic odt;
    logic cs_n;
  } fob_ctl_t;

  function automatic fob_mode_e fob_decode(input logic dup, input logic alt);
    if (!dup)    return FOB_WIDE;
    else if (alt) return FOB_DUP_B;
    else         return FOB_DUP_A;
  endfunction

  // Lane positions are fixed by the module wiring and so stay literal.
  function automatic logic [FOB_DAT_W-1:0] fob_keep_mask(input fob_mode_e m);
    logic [FOB_DAT_W-1:0] k;
    for (int i = 0; i < FOB_DAT_W; i++) begin
      case (m)
        FOB_WIDE:  k[i] = 1'b1;
        FOB_DUP_A: k[i] = (i == 1) || (i == 2) || (i == 4) || (i == 5) ||
                          (i >= 7 && i <= 13);
        default:   k[i] = (i <= 5) || (i >= 7 && i <= 9) || (i == 11) || (i == 12);
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/fob_rst_sync.sv
`timescale 1ns/1ps
module fob_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_nxt;
  end

  assign rst_sync_n = sh_q[STAGES-1];

  // R7: internal reset is never released while the pin reset is held
  p_release_after_pin_r7: assert property (@(posedge clk)
    !arst_n |-> !rst_sync_n);
endmodule

// File: rtl/fob_lane_map.sv
`timescale 1ns/1ps
module fob_lane_map
  import fob_pkg::*;
(
  input  logic                 dup_i,
  input  logic                 alt_i,
  input  logic [FOB_DAT_W-1:0] dat_i,
  input  fob_ctl_t             ctl_i,
  output logic [FOB_DAT_W-1:0] lane_a_o,
  output logic [FOB_DAT_W-1:0] lane_b_o,
  output fob_ctl_t             ctl_a_o,
  output fob_ctl_t             ctl_b_o
);
  fob_mode_e             mode;
  logic [FOB_DAT_W-1:0]  keep;
  logic                  twin;

  always_comb begin
    mode = fob_decode(dup_i, alt_i);
    keep = fob_keep_mask(mode);
    twin = (mode != FOB_WIDE);
  end

  for (genvar i = 0; i < FOB_DAT_W; i++) begin : g_lane
    assign lane_a_o[i] = dat_i[i] & keep[i];
    assign lane_b_o[i] = dat_i[i] & keep[i] & twin;
  end

  always_comb begin
    ctl_a_o = ctl_i;
    ctl_b_o = twin ? ctl_i : '0;
  end
endmodule

// File: rtl/fob_out_reg.sv
`timescale 1ns/1ps
module fob_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/fanout_reg_buf.sv
`timescale 1ns/1ps
module fanout_reg_buf
  import fob_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_dup,
  input  logic                 cfg_alt,
  input  logic                 csr_n_i,
  input  logic [FOB_DAT_W-1:0] dat_i,
  input  logic                 cke_i,
  input  logic                 odt_i,
  input  logic                 cs_n_i,
  output logic [FOB_DAT_W-1:0] datq_a_o,
  output logic [FOB_DAT_W-1:0] datq_b_o,
  output logic                 cke_a_o,
  output logic                 cke_b_o,
  output logic                 odt_a_o,
  output logic                 odt_b_o,
  output logic                 cs_n_a_o,
  output logic                 cs_n_b_o
);
  localparam int DATQ_W = 2 * FOB_DAT_W;
  localparam int CTLQ_W = 2 * FOB_CTL_W;

  logic                 rst_sync_n;
  logic                 dat_upd;
  fob_ctl_t             ctl_in;
  fob_ctl_t             ctl_a_nxt, ctl_b_nxt, ctl_a_q, ctl_b_q;
  logic [FOB_DAT_W-1:0] lane_a_nxt, lane_b_nxt;

  fob_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctl_in.cke  = cke_i;
    ctl_in.odt  = odt_i;
    ctl_in.cs_n = cs_n_i;
    dat_upd     = !(cs_n_i && csr_n_i);
  end

  fob_lane_map u_map (
    .dup_i    (cfg_dup),
    .alt_i    (cfg_alt),
    .dat_i    (dat_i),
    .ctl_i    (ctl_in),
    .lane_a_o (lane_a_nxt),
    .lane_b_o (lane_b_nxt),
    .ctl_a_o  (ctl_a_nxt),
    .ctl_b_o  (ctl_b_nxt)
  );

  fob_out_reg #(.W(DATQ_W)) u_datq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (dat_upd),
    .d     ({lane_a_nxt, lane_b_nxt}),
    .q     ({datq_a_o, datq_b_o})
  );

  fob_out_reg #(.W(CTLQ_W)) u_ctlq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (1'b1),
    .d     ({ctl_a_nxt, ctl_b_nxt}),
    .q     ({ctl_a_q, ctl_b_q})
  );

  always_comb begin
    cke_a_o  = ctl_a_q.cke;
    odt_a_o  = ctl_a_q.odt;
    cs_n_a_o = ctl_a_q.cs_n;
    cke_b_o  = ctl_b_q.cke;
    odt_b_o  = ctl_b_q.odt;
    cs_n_b_o = ctl_b_q.cs_n;
  end

  // R6: outputs low whenever the pin reset is held
  p_reset_low_r6: assert property (@(posedge clk)
    !rst_n |-> (datq_a_o == '0) && (datq_b_o == '0) &&
               !cke_a_o && !cke_b_o && !odt_a_o && !odt_b_o &&
               !cs_n_a_o && !cs_n_b_o);

  // R8: both selects idle -> data outputs keep their value
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs_n_i && csr_n_i) |=> $stable(datq_a_o) && $stable(datq_b_o));

  // R10: control outputs follow their inputs every cycle, gated or not
  p_ctl_ungated_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (cke_a_o == $past(cke_i)) && (odt_a_o == $past(odt_i)) &&
             (cs_n_a_o == $past(cs_n_i)));

  // R5: control copies agree in the duplicated layouts
  p_ctl_twins_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_dup |=> (cke_a_o == cke_b_o) && (odt_a_o == odt_b_o) &&
                (cs_n_a_o == cs_n_b_o));

  // R3 / R4: data copies agree after an ungated duplicated capture
  p_dat_twins_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_dup && !(cs_n_i && csr_n_i)) |=> (datq_a_o == datq_b_o));

  // R2: the wide layout leaves every B output low
  p_wide_b_low_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_dup && !(cs_n_i && csr_n_i)) |=> (datq_b_o == '0) &&
        !cke_b_o && !odt_b_o && !cs_n_b_o);
endmodule

// File: tb/fanout_reg_buf_test.sv
`timescale 1ns/1ps
module fanout_reg_buf_test;
  localparam int DW = 22;
  localparam logic [DW-1:0] MASK_A = 22'h003FB6;
  localparam logic [DW-1:0] MASK_B = 22'h001BBF;
  localparam int NV = 12;
  // {dup, alt, cs_n, csr_n, cke, odt, dat[21:0]}
  localparam logic [27:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 22'h2AAAAA},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 22'h155555},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 22'h3FFFFF},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0F0F0F},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 22'h3FFFFF},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 22'h123456},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 22'h3FFFFF},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 22'h000000},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 22'h2C3A51},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 22'h000000},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 22'h3FFFFF},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 22'h000001}
  };

  logic clk = 1'b0;
  logic rst_n, cfg_dup, cfg_alt, csr_n_i, cke_i, odt_i, cs_n_i;
  logic [DW-1:0] dat_i, datq_a_o, datq_b_o;
  logic cke_a_o, cke_b_o, odt_a_o, odt_b_o, cs_n_a_o, cs_n_b_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_da = '0, exp_db = '0;
  logic [5:0]    exp_ctl = '0;

  always #2.5 clk = ~clk;

  fanout_reg_buf uut (
    .clk(clk), .rst_n(rst_n), .cfg_dup(cfg_dup), .cfg_alt(cfg_alt),
    .csr_n_i(csr_n_i), .dat_i(dat_i), .cke_i(cke_i), .odt_i(odt_i),
    .cs_n_i(cs_n_i), .datq_a_o(datq_a_o), .datq_b_o(datq_b_o),
    .cke_a_o(cke_a_o), .cke_b_o(cke_b_o), .odt_a_o(odt_a_o),
    .odt_b_o(odt_b_o), .cs_n_a_o(cs_n_a_o), .cs_n_b_o(cs_n_b_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tdat, input string tctl);
    chk({tdat, " dataA"}, 32'(datq_a_o), 32'(exp_da));
    chk({tdat, " dataB"}, 32'(datq_b_o), 32'(exp_db));
    chk({tctl, " ctl"},
        32'({cke_a_o, odt_a_o, cs_n_a_o, cke_b_o, odt_b_o, cs_n_b_o}), 32'(exp_ctl));
  endtask

  task automatic drive(input logic [27:0] v);
    {cfg_dup, cfg_alt, cs_n_i, csr_n_i, cke_i, odt_i, dat_i} = v;
  endtask

  // Expected result of the next rising edge, from the requirements.
  task automatic model_edge();
    logic [DW-1:0] m;
    m = !cfg_dup ? {DW{1'b1}} : (cfg_alt ? MASK_B : MASK_A);
    if (!(cs_n_i && csr_n_i)) begin
      exp_da = dat_i & m;
      exp_db = cfg_dup ? (dat_i & m) : '0;
    end
    exp_ctl = {cke_i, odt_i, cs_n_i, (cfg_dup ? {cke_i, odt_i, cs_n_i} : 3'b000)};
  endtask

  task automatic clear_exp();
    exp_da = '0; exp_db = '0; exp_ctl = '0;
  endtask

  initial begin
    rst_n = 1'b1;
    drive('0);
    cs_n_i = 1'b1; csr_n_i = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk_all("R6 reset", "R6 reset");

    // R7: release with live inputs; two edges stay low, the third captures
    drive({1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 22'h3FFFFF});
    rst_n = 1'b1;
    @(negedge clk); chk_all("R7 edge1", "R7 edge1");
    @(negedge clk); chk_all("R7 edge2", "R7 edge2");
    model_edge();
    @(negedge clk); chk_all("R7 edge3", "R7 edge3");

    // R1: a change between edges is invisible until the next rising edge
    drive({1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 22'h00F00F});
    #1 chk_all("R1 before edge", "R1 before edge");
    model_edge();
    @(negedge clk); chk_all("R1 after edge", "R1 after edge");

    // table walk
    for (int k = 0; k < NV; k++) begin
      string td, tc;
      drive(VECS[k]);
      model_edge();
      if (cs_n_i && csr_n_i) td = "R8 hold";
      else if (!cfg_dup)     td = "R2 wide";
      else if (cfg_alt)      td = "R4 patB";
      else                   td = "R3 patA";
      if (cs_n_i && csr_n_i) tc = "R10 ungated";
      else if (cfg_dup)      tc = "R5 twin";
      else                   tc = "R2 wide";
      @(negedge clk);
      chk_all(td, tc);
    end

    // R12: layout change between edges applies at the next edge
    drive({1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 22'h3FFFFF});
    model_edge();
    @(negedge clk); chk_all("R12 patB", "R12 patB");
    cfg_dup = 1'b0;
    #1 chk_all("R12 before edge", "R12 before edge");
    model_edge();
    @(negedge clk); chk_all("R12 wide", "R12 wide");

    // R11: reset beats the select hold, clears without a clock edge (R6)
    cs_n_i = 1'b1; csr_n_i = 1'b1; dat_i = 22'h000000;
    model_edge();
    @(negedge clk); chk_all("R8 hold", "R10 ungated");
    #1 rst_n = 1'b0;
    clear_exp();
    #1 chk_all("R11 reset under hold", "R6 async");
    @(negedge clk); chk_all("R6 held", "R6 held");

    // re-release, then R9: either select alone enables updates
    drive({1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 22'h111111});
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk_all("R7 second release", "R7 second release");
    model_edge();
    @(negedge clk); chk_all("R9 cs only", "R9 cs only");
    drive({1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 22'h2FFFF6});
    model_edge();
    @(negedge clk); chk_all("R9 csr only", "R9 csr only");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule